// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the peripheral clock into a one-cycle enable pulse that repeats at sixteen times the chosen serial bit rate. The transmitter and the receiver of a serial port both use this pulse as their oversampling tick. The pulse rate comes from two cascaded stages:

- A fractional stage first drops some clock cycles, so the clock is slowed by the factor `(mul + add) / mul`.
- A 16-bit integer divisor then passes one pulse for every `divisor` cycles that survive the first stage.

Both stages restart from zero on any change to the configuration inputs. The same restart happens on the first clock after reset. Because of this, a fresh setting always starts from a known phase. Settings that are out of range are mapped to defined behaviour rather than left open. A flag reports the one combination that produces too coarse a rate.

Top module: `frac_baud_gen`

## Requirements
- R1: The integer divisor is `{div_hi, div_lo}`, with `div_hi` as bits 15:8 and `div_lo` as bits 7:0. When the fractional stage is bypassed, `tick16` pulses once every `divisor` clock cycles.
- R2: A divisor of 0x0000 acts exactly like 0x0001. With the fractional stage bypassed as well, `tick16` is high on every cycle.
- R3: When `frac_add` is 0, the fractional stage drops no cycles.
- R4: When `frac_add` is nonzero, the fractional stage lets exactly `M` cycles through out of every `M + frac_add` cycles. The pattern is evenly spread: relative cycle j passes when floor((j+1)·M/(M+frac_add)) exceeds floor(j·M/(M+frac_add)).
- R5: A `frac_mul` value of 0 is treated as 1. Here `M` is that cleaned value.
- R6: `config_error` goes high one cycle after the inputs show `frac_add != 0`, `div_hi == 0` and `div_lo < 3`. Otherwise it is low.
- R7: A change on any configuration input, and the first clock edge after reset, clears both stages. `tick16` is then 0 in the following cycle. Counting restarts at relative cycle 0 in the cycle after that edge. A tick appears one cycle after the relative cycle in which the P-th passed cycle is counted, where P is a multiple of the divisor.
- R8: During reset, `tick16` and `config_error` are 0. Each tick lasts one cycle whenever the divisor is 2 or more.
- R9: Over a long window, the number of ticks equals floor(floor(L·M/(M+frac_add))/divisor) for L processed cycles. This is the rate PCLK/(divisor·(1+frac_add/M)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_lo | input | 8 | Divisor bits 7:0 |
| div_hi | input | 8 | Divisor bits 15:8 |
| frac_add | input | 4 | Fractional add value; 0 bypasses the fractional stage |
| frac_mul | input | 4 | Fractional multiplier; 0 is read as 1 |
| tick16 | output | 1 | One-cycle enable at 16x the bit rate |
| config_error | output | 1 | Flags a fractional setting combined with a divisor below 3 |

## Verification
The bench covers the following corner cases:

- **Zero divisor.** A design that takes zero literally would never wrap, or would wrap only after 65536 cycles. The all-zero divisor shows this.
- **Zero multiplier.** A zero `frac_mul` would stall the fractional stage or let it pass every cycle.
- **Add value larger than the multiplier.** A stage that subtracts the multiplier on overflow would drop more cycles than it keeps.
- **Reconfiguration mid-count.** The configuration is changed while a count is in progress. A design that kept its old phase would place the next ticks at the wrong cycles.
- **Error flag.** The flag is checked on both sides of the `div_lo == 3` boundary, and with the high byte both zero and nonzero.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
    localparam int unsigned LO_BITS   = 8;
    localparam int unsigned HI_BITS   = 8;
    localparam int unsigned FRAC_BITS = 4;
    localparam int unsigned MIN_LO_FRAC = 3;

    // Values of zero are mapped to one so every ratio stays defined.
    function automatic logic [31:0] at_least_one(input logic [31:0] v);
        return (v == 32'd0) ? 32'd1 : v;
    endfunction
endpackage

// File: rtl/fbg_cfg_track.sv
module fbg_cfg_track
    import frac_baud_pkg::*;
#(
    parameter int unsigned LO_W   = LO_BITS,
    parameter int unsigned HI_W   = HI_BITS,
    parameter int unsigned FRAC_W = FRAC_BITS,
    localparam int unsigned DIV_W = LO_W + HI_W,
    localparam int unsigned RAW_W = DIV_W + 2 * FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LO_W-1:0]   lo_in,
    input  logic [HI_W-1:0]   hi_in,
    input  logic [FRAC_W-1:0] add_in,
    input  logic [FRAC_W-1:0] mul_in,
    output logic              restart,
    output logic [DIV_W-1:0]  div_eff,
    output logic [FRAC_W-1:0] add_eff,
    output logic [FRAC_W-1:0] mul_eff,
    output logic              err
);
    typedef struct packed {
        logic [RAW_W-1:0] snap;
        logic             primed;
        logic             err;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [RAW_W-1:0] raw;
    logic [DIV_W-1:0] div_raw;

    assign raw     = {hi_in, lo_in, add_in, mul_in};
    assign div_raw = {hi_in, lo_in};

    always_comb begin
        trk_d        = trk_q;
        trk_d.snap   = raw;
        trk_d.primed = 1'b1;
        trk_d.err    = (add_in != '0) && (hi_in == '0) && (lo_in < LO_W'(MIN_LO_FRAC));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign restart = !trk_q.primed || (raw != trk_q.snap);
    assign div_eff = DIV_W'(at_least_one(32'(div_raw)));
    assign mul_eff = FRAC_W'(at_least_one(32'(mul_in)));
    assign add_eff = add_in;
    assign err     = trk_q.err;
endmodule

// File: rtl/fbg_frac_pre.sv
module fbg_frac_pre
    import frac_baud_pkg::*;
#(
    parameter int unsigned FRAC_W = FRAC_BITS,
    localparam int unsigned ACC_W = FRAC_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [FRAC_W-1:0] add_val,
    input  logic [FRAC_W-1:0] mul_val,
    output logic              pass
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] span;

    // Phase accumulator with modulus mul+add: advances by mul each cycle
    // and lets the cycle through whenever it wraps the modulus.
    always_comb begin
        span  = ACC_W'(mul_val) + ACC_W'(add_val);
        sum   = pre_q.acc + ACC_W'(mul_val);
        pass  = (sum >= span);
        pre_d = pre_q;
        if (restart)   pre_d.acc = '0;
        else if (pass) pre_d.acc = sum - span;
        else           pre_d.acc = sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/fbg_int_div.sv
module fbg_int_div
    import frac_baud_pkg::*;
#(
    parameter int unsigned DIV_W = LO_BITS + HI_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             pass,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } dv_t;

    dv_t dv_d, dv_q;
    logic wrap;

    always_comb begin
        wrap = (dv_q.cnt == div_val - DIV_W'(1));
        dv_d = dv_q;
        dv_d.tick = 1'b0;
        if (restart) begin
            dv_d.cnt = '0;
        end else if (pass) begin
            dv_d.tick = wrap;
            dv_d.cnt  = wrap ? '0 : dv_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign tick = dv_q.tick;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int unsigned LO_W   = LO_BITS,
    parameter int unsigned HI_W   = HI_BITS,
    parameter int unsigned FRAC_W = FRAC_BITS,
    localparam int unsigned DIV_W = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LO_W-1:0]   div_lo,
    input  logic [HI_W-1:0]   div_hi,
    input  logic [FRAC_W-1:0] frac_add,
    input  logic [FRAC_W-1:0] frac_mul,
    output logic              tick16,
    output logic              config_error
);
    logic              restart;
    logic              pass;
    logic [DIV_W-1:0]  div_eff;
    logic [FRAC_W-1:0] add_eff;
    logic [FRAC_W-1:0] mul_eff;

    fbg_cfg_track #(.LO_W(LO_W), .HI_W(HI_W), .FRAC_W(FRAC_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_in   (div_lo),
        .hi_in   (div_hi),
        .add_in  (frac_add),
        .mul_in  (frac_mul),
        .restart (restart),
        .div_eff (div_eff),
        .add_eff (add_eff),
        .mul_eff (mul_eff),
        .err     (config_error)
    );

    fbg_frac_pre #(.FRAC_W(FRAC_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .add_val (add_eff),
        .mul_val (mul_eff),
        .pass    (pass)
    );

    fbg_int_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .pass    (pass),
        .div_val (div_eff),
        .tick    (tick16)
    );
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
    parameter int unsigned LO_W   = 8,
    parameter int unsigned HI_W   = 8,
    parameter int unsigned FRAC_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LO_W-1:0]   div_lo,
    input logic [HI_W-1:0]   div_hi,
    input logic [FRAC_W-1:0] frac_add,
    input logic [FRAC_W-1:0] frac_mul,
    input logic              tick16,
    input logic              config_error
);
    logic up_q;
    logic [FRAC_W-1:0] m_clean;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= 1'b1;
    end

    assign m_clean = (frac_mul == '0) ? FRAC_W'(1) : frac_mul;

    p_err_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> config_error ==
            $past((frac_add != '0) && (div_hi == '0) && (div_lo < LO_W'(3))));

    p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && !$stable({div_hi, div_lo, frac_add, frac_mul})) |=> !tick16);

    p_zero_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && $stable({div_hi, div_lo, frac_add, frac_mul}) &&
         {div_hi, div_lo} == '0 && frac_add == '0) |=> tick16);

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick16 && ({div_hi, div_lo} >= (LO_W + HI_W)'(2))) |=> !tick16);

    p_swallow_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick16 && frac_add != '0 && frac_add >= m_clean) |=> !tick16);
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.LO_W(LO_W), .HI_W(HI_W), .FRAC_W(FRAC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .div_lo       (div_lo),
    .div_hi       (div_hi),
    .frac_add     (frac_add),
    .frac_mul     (frac_mul),
    .tick16       (tick16),
    .config_error (config_error)
);

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_lo = 8'd0;
    logic [7:0] div_hi = 8'd0;
    logic [3:0] frac_add = 4'd0;
    logic [3:0] frac_mul = 4'd0;
    logic       tick16;
    logic       config_error;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    longint e = 0;
    longint seen = 0;

    always #2 clk = ~clk;

    frac_baud_gen u_frac_baud_gen (
        .clk(clk), .rst_n(rst_n), .div_lo(div_lo), .div_hi(div_hi),
        .frac_add(frac_add), .frac_mul(frac_mul),
        .tick16(tick16), .config_error(config_error)
    );

    function automatic longint m_val();
        return (frac_mul == 0) ? 1 : longint'(frac_mul);
    endfunction
    function automatic longint d_val();
        longint d = longint'({div_hi, div_lo});
        return (d == 0) ? 1 : d;
    endfunction
    function automatic longint passes(longint k);
        return (k * m_val()) / (m_val() + longint'(frac_add));
    endfunction
    function automatic bit want_tick(longint j);
        longint p1 = passes(j + 1);
        return (p1 != passes(j)) && (p1 % d_val() == 0);
    endfunction
    function automatic bit want_err();
        return (frac_add != 0) && (div_hi == 0) && (div_lo < 8'd3);
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic setcfg(logic [7:0] lo, logic [7:0] hi, logic [3:0] a, logic [3:0] m);
        div_lo = lo; div_hi = hi; frac_add = a; frac_mul = m;
        e = 0; seen = 0;
    endtask

    task automatic run(longint n, string req);
        for (longint i = 0; i < n; i++) begin
            @(negedge clk);
            e++;
            check(req, "tick16", tick16, (e >= 2) ? want_tick(e - 2) : 0);
            check("R6", "config_error", config_error, want_err());
            if (tick16) seen++;
        end
        check("R9", "tick count", seen, passes(e - 1) / d_val());
    endtask

    initial begin
        #(150000 * 4);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        setcfg(8'd4, 8'd0, 4'd0, 4'd1);
        repeat (3) @(negedge clk);
        check("R8", "reset tick16", tick16, 0);
        check("R8", "reset config_error", config_error, 0);
        rst_n = 1'b1;
        e = 0; seen = 0;
        run(200, "R3");
        // R2: zero divisor acts as one
        setcfg(8'd0, 8'd0, 4'd0, 4'd5);
        run(100, "R2");
        // R5: zero multiplier taken as one, divisor 2, error flagged
        setcfg(8'd2, 8'd0, 4'd1, 4'd0);
        run(400, "R5");
        // R4: fractional 3/4 with divisor 5
        setcfg(8'd5, 8'd0, 4'd3, 4'd4);
        run(2000, "R4");
        // R4: add much larger than mul, divisor exactly 3 (no error)
        setcfg(8'd3, 8'd0, 4'd15, 4'd1);
        run(3000, "R4");
        // R1: high byte used, low byte zero with fraction, no error
        setcfg(8'd0, 8'd1, 4'd2, 4'd7);
        run(4000, "R1");
        // R7: change mid-count
        setcfg(8'd7, 8'd0, 4'd0, 4'd3);
        run(11, "R7");
        setcfg(8'd6, 8'd0, 4'd5, 4'd9);
        run(37, "R7");
        setcfg(8'd6, 8'd0, 4'd5, 4'd8);
        run(1500, "R7");
        // R9: long window with odd ratio
        setcfg(8'd13, 8'd0, 4'd11, 4'd13);
        run(6000, "R9");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule